// File: doc/BRIEF.md
# Prescaled Interrupting Timer Bank

A register-mapped timer peripheral with four counters on a 16-bit word bus. The first counter (t0) divides the system clock and produces a one-cycle tick, so it serves as a programmable prescaler for the other three. Counters t1, t2 and t3 each count those ticks against their own divisor. When one of them expires it sets a sticky status flag. If that counter's interrupt enable is set, the flag drives the single combined interrupt line.

Software programs each divisor register, then sets the enables in the shared control word. After an interrupt it reads the control word to find the source, and it clears the flag by writing a one to that flag's bit. A divisor of zero stops its counter. If the prescaler divisor is zero, every counter stops. Bus addresses are byte offsets and the registers are word aligned.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset all four divisors and the control word read as 0x0000, `irq_o` is low and `bus_rdata` is 0x0000.
- R2: The divisors of t0, t1, t2 and t3 sit at offsets 0x10, 0x12, 0x14 and 0x16, and the control word sits at 0x0E. Each register reads back its current value. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low.
- R3: With a t0 divisor N greater than 0, the prescaler ticks exactly once every N system clock cycles. N = 1125 with a 112.5 MHz clock gives a 100 kHz tick.
- R4: When counter tk (k = 1 to 3) has a divisor M greater than 0, it expires once every M prescaler ticks and sets control bit 7+k. These are bit 8 for t1, bit 9 for t2 and bit 10 for t3.
- R5: Control bits 0, 1 and 2 are the interrupt enables of t1, t2 and t3. `irq_o` is high exactly when some enabled counter has its flag set, and a flag whose enable is clear does not raise `irq_o`.
- R6: Status flags are sticky. A control write clears each flag whose bit in the write data is 1 and leaves a flag alone where that bit is 0. If an expiry and a clear of the same flag fall in one cycle, the flag ends up set.
- R7: A write to a divisor register loads the new value and restarts that counter from zero.
- R8: A divisor of zero stops its counter, so it never expires. A t0 divisor of zero stops all prescaler ticks.
- R9: Any other address, including the odd byte addresses, reads as 0x0000, and writes to it change no register.
- R10: Control bits 7:3 and 15:11 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register being accessed |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W (16) | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each bus access lasts a single cycle with a stable address, that reads and writes never overlap in one cycle, and that software clears flags only through the control word. The stimulus drives every strobe for exactly one cycle from the falling clock edge, and it never raises both strobes at once. Expiry-related checks are timed in cycles from the write that starts the prescaler. One sequence deliberately places a flag clear on the same edge as an expiry, to exercise the set-over-clear priority.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int TMR_ADDR_W   = 5;
    localparam int TMR_DATA_W   = 16;
    localparam int TMR_NUM_CNT  = 4;           // prescaler plus three interrupting counters
    localparam int TMR_CTRL_OFS = 'h0E;        // shared enable/flag word
    localparam int TMR_DIV_OFS  = 'h10;        // divisor of counter 0, others follow by 2
    localparam int TMR_EN_LSB   = 0;           // enables of t1..t3
    localparam int TMR_FLAG_LSB = 8;           // flags of t1..t3
endpackage

// File: rtl/tmr_divider.sv
`timescale 1ns/1ps
module tmr_divider #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] div_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_end;

    assign at_end   = (st_q.div != '0) && (st_q.cnt == st_q.div - 1'b1);
    assign expire_o = step_i && at_end && !load_i;
    assign div_o    = st_q.div;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.div = load_val_i;
            st_d.cnt = '0;
        end else if (step_i && st_q.div != '0) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int NUM_IRQ = 3,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_IRQ-1:0] expire_i,
    output logic [NUM_IRQ-1:0] flags_o,
    output logic [DATA_W-1:0]  word_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] en;
        logic [NUM_IRQ-1:0] flag;
    } ctrl_state_t;

    ctrl_state_t        st_d, st_q;
    logic [NUM_IRQ-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (wr_i) begin
            st_d.en  = wdata_i[TMR_EN_LSB +: NUM_IRQ];
            clr_mask = wdata_i[TMR_FLAG_LSB +: NUM_IRQ];
        end
        // set beats clear when both land on one edge
        st_d.flag = (st_q.flag & ~clr_mask) | expire_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_o = '0;
        word_o[TMR_EN_LSB   +: NUM_IRQ] = st_q.en;
        word_o[TMR_FLAG_LSB +: NUM_IRQ] = st_q.flag;
    end

    assign flags_o = st_q.flag;
    assign irq_o   = |(st_q.en & st_q.flag);
endmodule

// File: rtl/tick_timer_bank.sv
`timescale 1ns/1ps
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int ADDR_W = TMR_ADDR_W,
    parameter int DATA_W = TMR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int NUM_CNT = TMR_NUM_CNT;
    localparam int NUM_IRQ = NUM_CNT - 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    logic [NUM_CNT-1:0] div_hit;
    logic [NUM_CNT-1:0] expire_w;
    logic [NUM_CNT-1:0] step_w;
    logic [DATA_W-1:0]  div_w [NUM_CNT];
    logic [DATA_W-1:0]  ctrl_word;
    logic [NUM_IRQ-1:0] flag_w;
    logic               ctrl_hit;
    logic [DATA_W-1:0]  rd_mux;
    rd_state_t          rd_d, rd_q;

    assign ctrl_hit = (bus_addr == ADDR_W'(TMR_CTRL_OFS));
    assign step_w[0] = 1'b1;                 // prescaler runs on every clock

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        assign div_hit[g] = (bus_addr == ADDR_W'(TMR_DIV_OFS + 2 * g));
        if (g > 0) begin : g_tick
            assign step_w[g] = expire_w[0];
        end
        tmr_divider #(.CNT_W(DATA_W)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (bus_wr && div_hit[g]),
            .load_val_i (bus_wdata),
            .step_i     (step_w[g]),
            .div_o      (div_w[g]),
            .expire_o   (expire_w[g])
        );
    end

    tmr_ctrl #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr && ctrl_hit),
        .wdata_i  (bus_wdata),
        .expire_i (expire_w[NUM_CNT-1:1]),
        .flags_o  (flag_w),
        .word_o   (ctrl_word),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (ctrl_hit) rd_mux = ctrl_word;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (div_hit[i]) rd_mux = div_w[i];
        end
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/tmr_bank_chk.sv
`timescale 1ns/1ps
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = TMR_ADDR_W,
    parameter int DATA_W  = TMR_DATA_W,
    parameter int NUM_IRQ = TMR_NUM_CNT - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [NUM_IRQ-1:0] flag_w
);
    logic ctl_wr;
    logic is_div;
    logic mapped;

    assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(TMR_CTRL_OFS));
    assign is_div = !bus_addr[0] && (bus_addr >= ADDR_W'(TMR_DIV_OFS))
                    && (bus_addr <= ADDR_W'(TMR_DIV_OFS + 2 * (NUM_IRQ)));
    assign mapped = is_div || (bus_addr == ADDR_W'(TMR_CTRL_OFS));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R2
    div_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_div && $past(bus_wr) && $past(bus_addr) == bus_addr)
        |=> bus_rdata == $past(bus_wdata, 2));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> bus_rdata == '0);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ((flag_w & $past(flag_w)) == $past(flag_w)));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctl_wr) |=> irq_o);
endmodule

bind tick_timer_bank tmr_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .flag_w    (flag_w)
);

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
    localparam int CLK_NS = 4;   // 250 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic rd_seen = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    tick_timer_bank i_tick_timer_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= bus_rd;
    end

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [15:0] e;
            string t;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL unexpected read result act=%h exp=none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s read act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int c1;
        int per;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 irq", {15'b0, irq_o}, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        rd(5'h0E, 16'h0, "R1 ctrl");
        rd(5'h10, 16'h0, "R1 div0");
        rd(5'h12, 16'h0, "R1 div1");
        rd(5'h14, 16'h0, "R1 div2");
        rd(5'h16, 16'h0, "R1 div3");

        // R2 readback
        wr(5'h10, 16'h1234); wr(5'h12, 16'h0A5A);
        wr(5'h14, 16'hBEEF); wr(5'h16, 16'h0F0F);
        rd(5'h10, 16'h1234, "R2 div0");
        rd(5'h12, 16'h0A5A, "R2 div1");
        rd(5'h14, 16'hBEEF, "R2 div2");
        rd(5'h16, 16'h0F0F, "R2 div3");
        idle(3);
        check("R2 hold", bus_rdata, 16'h0F0F);

        // R3 prescaler period 1125
        wr(5'h10, 16'h0); wr(5'h14, 16'h0); wr(5'h16, 16'h0);
        wr(5'h12, 16'd1); wr(5'h0E, 16'h0701);
        wr(5'h10, 16'd1125);
        n = 0;
        while (!irq_o && n < 5000) begin @(negedge clk); n++; end
        check("R3 first tick", 16'(n), 16'd1125);
        c1 = cyc;
        wr(5'h0E, 16'h0101);
        n = 0;
        while (!irq_o && n < 5000) begin @(negedge clk); n++; end
        per = cyc - c1;
        check("R3 period", 16'(per), 16'd1125);
        check("R3 100kHz", 16'((per > 0) ? (112_500_000 / per) / 10 : 0), 16'd10000);

        // R4 / R5 / R6 / R8 expiry, flags and clearing
        wr(5'h10, 16'h0);
        wr(5'h0E, 16'h0703);
        wr(5'h12, 16'd3); wr(5'h14, 16'd5); wr(5'h16, 16'd0);
        wr(5'h10, 16'd2);                 // k=0
        idle(5);                          // k=5
        check("R4 t1 not yet", {15'b0, irq_o}, 16'h0);
        idle(1);                          // k=6
        check("R4 t1 expired", {15'b0, irq_o}, 16'h1);
        rd(5'h0E, 16'h0103, "R4 flag bit8");          // k=7
        wr(5'h0E, 16'h0103);              // k=8, clears bit 8
        check("R6 clear", {15'b0, irq_o}, 16'h0);
        idle(1);
        check("R5 quiet", {15'b0, irq_o}, 16'h0);
        idle(1);                          // k=10
        check("R4 t2 expired", {15'b0, irq_o}, 16'h1);
        rd(5'h0E, 16'h0203, "R4 flag bit9");          // k=11
        wr(5'h0E, 16'h0103);              // edge 12: clear and t1 expiry together
        rd(5'h0E, 16'h0303, "R6 set wins / R8 t3 idle");

        // R5 flag without enable
        wr(5'h0E, 16'h0002);              // disable t1, keep t2 enabled
        wr(5'h0E, 16'h0200);              // clear t2 flag only, all enables off
        idle(4);
        check("R5 masked", {15'b0, irq_o}, 16'h0);
        rd(5'h0E, 16'h0100, "R5 t1 flag kept");

        // R7 reload restarts the count
        wr(5'h10, 16'h0);
        wr(5'h0E, 16'h0701);
        wr(5'h12, 16'd4); wr(5'h14, 16'd0);
        wr(5'h10, 16'd1);                 // k=0
        idle(2);                          // k=2
        wr(5'h12, 16'd4);                 // k=3
        idle(1);
        check("R7 no early expiry", {15'b0, irq_o}, 16'h0);
        idle(2);
        check("R7 still counting", {15'b0, irq_o}, 16'h0);
        idle(1);                          // k=7
        check("R7 restarted expiry", {15'b0, irq_o}, 16'h1);

        // R8 halted prescaler
        wr(5'h10, 16'h0);
        wr(5'h0E, 16'h0701);
        wr(5'h12, 16'd1);
        idle(40);
        check("R8 halted", {15'b0, irq_o}, 16'h0);
        rd(5'h0E, 16'h0001, "R8 no flags");

        // R9 unmapped
        wr(5'h00, 16'hABCD);
        wr(5'h11, 16'h1234);
        rd(5'h00, 16'h0, "R9 addr00");
        rd(5'h18, 16'h0, "R9 addr18");
        rd(5'h11, 16'h0, "R9 odd");
        rd(5'h12, 16'd1, "R9 div1 intact");
        rd(5'h10, 16'h0, "R9 div0 intact");

        // R10 reserved control bits
        wr(5'h0E, 16'hFFFF);
        rd(5'h0E, 16'h0007, "R10 reserved");
        check("R10 irq", {15'b0, irq_o}, 16'h0);

        idle(3);
        check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule